// File: doc/BRIEF.md
# Signed Multiply-Accumulate Sum Sequencer

This block is a multi-cycle engine that forms the signed dot product of two arrays held in memory. One start pulse hands it two byte-address pointers, an element count, an element size and a 96-bit starting sum split into low, middle and high 32-bit words. For each element it reads one value from each array, sign-extends both, multiplies them as signed numbers, and adds the 64-bit product into the running sum. Each pass then moves the pointers forward by the element size and lowers the count by one.

When the count reaches zero, the high word is sign-extended from its bit 15. The result is an effective 80-bit signed sum. The engine then sets a sign flag and an overflow flag from that high word, reports a fixed cost figure in cycles for the whole operation, and gives a one-cycle done pulse. The two read ports share a single strobe. Each port returns its element right-aligned, one cycle after the strobe. Arbitration for those ports and decode of the triggering operation are done outside this block.

Top module: `mac_seq_top`

## Requirements
- R1: After a synchronous active-high reset, busy, done, mem_rd, flag_s, flag_o and every result word are 0.
- R2: Each element gives exactly one mem_rd pulse. mem_rd is high only while busy. On the k-th read (k from 0), mem_addr_a and mem_addr_b equal the start pointers plus k times the element size in bytes.
- R3: Size code 00 selects byte elements (bits 7:0), 01 selects halfword elements (bits 15:0), and 10 or 11 select word elements. The bits of read data above the element are ignored, and the element is sign-extended to 32 bits.
- R4: The final sum equals the starting 96-bit sum {sum_hi, sum_mid, sum_lo} plus the 96-bit sign extension of every signed product, modulo 2^96. When at least one element was processed, bits 31:16 of the final sum_hi are then replaced by copies of its bit 15.
- R5: At completion, ptr_a_o and ptr_b_o have each advanced by n times the element size (1, 2 or 4 bytes), and count_o is 0. While busy, count_o only ever steps down by one.
- R6: At completion, flag_s equals bit 31 of the final sum_hi. flag_o is 1 exactly when the final sum_hi is neither 0 nor all ones.
- R7: cost_o is 6+4n for word elements, 6+5*floor(n/2)+4*(n mod 2) for halfword elements, and 6+7*floor(n/4)+4*(n mod 4) for byte elements. It is set at start and holds steady while busy.
- R8: With a count of 0 at start, no read is made. Pointers and all three sum words are returned unchanged, with no sign extension. The flags are formed from the unchanged sum_hi.
- R9: done is high for exactly one cycle per operation, and busy is low while done is high. A start pulse while busy has no effect on the running operation.
- R10: Read data is taken in the clock cycle that follows the cycle in which mem_rd is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation when idle |
| ptr_a_in | input | 32 | Start byte address of array A |
| ptr_b_in | input | 32 | Start byte address of array B |
| count_in | input | 32 | Number of element pairs |
| esize_in | input | 2 | Element size code (00 byte, 01 halfword, 1x word) |
| sum_lo_in | input | 32 | Starting sum, bits 31:0 |
| sum_mid_in | input | 32 | Starting sum, bits 63:32 |
| sum_hi_in | input | 32 | Starting sum, bits 95:64 |
| mem_rdata_a | input | 32 | Array A element, right-aligned |
| mem_rdata_b | input | 32 | Array B element, right-aligned |
| mem_rd | output | 1 | Read strobe for both ports |
| mem_addr_a | output | 32 | Read address for array A |
| mem_addr_b | output | 32 | Read address for array B |
| ptr_a_o | output | 32 | Current/final A pointer |
| ptr_b_o | output | 32 | Current/final B pointer |
| count_o | output | 32 | Remaining element count |
| sum_lo_o | output | 32 | Sum bits 31:0 |
| sum_mid_o | output | 32 | Sum bits 63:32 |
| sum_hi_o | output | 32 | Sum bits 95:64 |
| flag_s | output | 1 | Sign of final sum_hi |
| flag_o | output | 1 | Final sum_hi outside 0 / all ones |
| cost_o | output | 32 | Cycle cost figure of the operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume a memory that honours the one-cycle read latency. They also assume that start is only meaningful while idle, so a start while busy must be ignored, not acted on. The stimulus uses a bench memory that answers every strobe on the next edge with data derived from the address. That data carries random bits above the element, so any leak of those bits shows up in the sum. The bench also raises start partway through one run with different operands, to show that the request is dropped.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WALT = 2'b11
  } esize_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT,
    ST_MUL,
    ST_ACC,
    ST_FIN
  } state_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/mac_elem_ext.sv
module mac_elem_ext #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] raw,
  input  logic [1:0]    esize,
  output logic [DW-1:0] val
);
  import mac_pkg::*;
  always_comb begin
    case (esize)
      SZ_BYTE: val = {{(DW-8){raw[7]}}, raw[7:0]};
      SZ_HALF: val = {{(DW-16){raw[15]}}, raw[15:0]};
      default: val = raw;
    endcase
  end
endmodule

// File: rtl/mac_cost.sv
module mac_cost #(
  parameter int CW = 32
) (
  input  logic [CW-1:0] n,
  input  logic [1:0]    esize,
  output logic [CW-1:0] cost
);
  import mac_pkg::*;
  localparam logic [CW-1:0] BASE = CW'(6);
  logic [CW-1:0] pairs, quads, odd1, rem4;
  assign pairs = n >> 1;
  assign quads = n >> 2;
  assign odd1  = {{(CW-1){1'b0}}, n[0]};
  assign rem4  = {{(CW-2){1'b0}}, n[1:0]};
  always_comb begin
    case (esize)
      SZ_BYTE: cost = BASE + quads * CW'(7) + (rem4 << 2);
      SZ_HALF: cost = BASE + pairs * CW'(5) + (odd1 << 2);
      default: cost = BASE + (n << 2);
    endcase
  end
endmodule

// File: rtl/mac_seq_top.sv
module mac_seq_top #(
  parameter int DW      = 32,
  parameter int AW      = 32,
  parameter int CW      = 32,
  parameter int EXT_BIT = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] ptr_a_in,
  input  logic [AW-1:0] ptr_b_in,
  input  logic [CW-1:0] count_in,
  input  logic [1:0]    esize_in,
  input  logic [DW-1:0] sum_lo_in,
  input  logic [DW-1:0] sum_mid_in,
  input  logic [DW-1:0] sum_hi_in,
  input  logic [DW-1:0] mem_rdata_a,
  input  logic [DW-1:0] mem_rdata_b,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr_a,
  output logic [AW-1:0] mem_addr_b,
  output logic [AW-1:0] ptr_a_o,
  output logic [AW-1:0] ptr_b_o,
  output logic [CW-1:0] count_o,
  output logic [DW-1:0] sum_lo_o,
  output logic [DW-1:0] sum_mid_o,
  output logic [DW-1:0] sum_hi_o,
  output logic          flag_s,
  output logic          flag_o,
  output logic [CW-1:0] cost_o,
  output logic          busy,
  output logic          done
);
  import mac_pkg::*;
  localparam int PW = 2 * DW;
  localparam int SW = 3 * DW;

  state_t              state;
  logic [1:0]          esz;
  logic [SW-1:0]       acc;
  logic signed [PW-1:0] prod_r;
  logic                looped;
  logic [DW-1:0]       ext_a, ext_b;
  logic [CW-1:0]       cost_w;
  logic [DW-1:0]       hi_final;
  logic [AW-1:0]       step;

  mac_elem_ext #(.DW(DW)) u_ext_a (.raw(mem_rdata_a), .esize(esz), .val(ext_a));
  mac_elem_ext #(.DW(DW)) u_ext_b (.raw(mem_rdata_b), .esize(esz), .val(ext_b));
  mac_cost #(.CW(CW)) u_cost (.n(count_in), .esize(esize_in), .cost(cost_w));

  assign step = AW'(size_bytes(esz));
  assign hi_final = looped
    ? {{(DW-EXT_BIT-1){acc[2*DW+EXT_BIT]}}, acc[2*DW+EXT_BIT:2*DW]}
    : acc[SW-1:2*DW];

  assign sum_lo_o  = acc[DW-1:0];
  assign sum_mid_o = acc[2*DW-1:DW];
  assign sum_hi_o  = acc[SW-1:2*DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      esz        <= 2'b00;
      acc        <= '0;
      prod_r     <= '0;
      looped     <= 1'b0;
      ptr_a_o    <= '0;
      ptr_b_o    <= '0;
      count_o    <= '0;
      cost_o     <= '0;
      mem_rd     <= 1'b0;
      mem_addr_a <= '0;
      mem_addr_b <= '0;
      flag_s     <= 1'b0;
      flag_o     <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      done   <= 1'b0;
      mem_rd <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          ptr_a_o <= ptr_a_in;
          ptr_b_o <= ptr_b_in;
          count_o <= count_in;
          esz     <= esize_in;
          acc     <= {sum_hi_in, sum_mid_in, sum_lo_in};
          cost_o  <= cost_w;
          looped  <= 1'b0;
          busy    <= 1'b1;
          state   <= ST_CHECK;
        end
        ST_CHECK: begin
          if (count_o == '0) begin
            state <= ST_FIN;
          end else begin
            mem_rd     <= 1'b1;
            mem_addr_a <= ptr_a_o;
            mem_addr_b <= ptr_b_o;
            state      <= ST_WAIT;
          end
        end
        ST_WAIT: state <= ST_MUL;
        ST_MUL: begin
          prod_r <= $signed(ext_a) * $signed(ext_b);
          state  <= ST_ACC;
        end
        ST_ACC: begin
          acc     <= acc + {{(SW-PW){prod_r[PW-1]}}, prod_r};
          ptr_a_o <= ptr_a_o + step;
          ptr_b_o <= ptr_b_o + step;
          count_o <= count_o - CW'(1);
          looped  <= 1'b1;
          state   <= ST_CHECK;
        end
        ST_FIN: begin
          acc[SW-1:2*DW] <= hi_final;
          flag_s <= hi_final[DW-1];
          flag_o <= (hi_final != '0) && (hi_final != '1);
          busy   <= 1'b0;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_seq_chk.sv
module mac_seq_chk #(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] cost_o,
  input logic [DW-1:0] sum_hi_o,
  input logic          flag_s,
  input logic          flag_o
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  rd_busy_chk: assert property (@(posedge clk) disable iff (rst) mem_rd |-> busy);
  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst) mem_rd |=> !mem_rd);
  // R6
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> flag_s == sum_hi_o[DW-1]);
  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> flag_o == ((sum_hi_o != '0) && (sum_hi_o != '1)));
  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && count_o != $past(count_o)) |-> count_o == $past(count_o) - CW'(1));
  // R7
  cost_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cost_o));
endmodule

bind mac_seq_top mac_seq_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_rd(mem_rd),
  .count_o(count_o), .cost_o(cost_o), .sum_hi_o(sum_hi_o),
  .flag_s(flag_s), .flag_o(flag_o)
);

// File: tb/sim_mac_seq_top.sv
module sim_mac_seq_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] ptr_a_in = '0, ptr_b_in = '0, count_in = '0;
  logic [1:0]  esize_in = 2'b00;
  logic [31:0] sum_lo_in = '0, sum_mid_in = '0, sum_hi_in = '0;
  logic [31:0] mem_rdata_a = '0, mem_rdata_b = '0;
  logic        mem_rd;
  logic [31:0] mem_addr_a, mem_addr_b, ptr_a_o, ptr_b_o, count_o;
  logic [31:0] sum_lo_o, sum_mid_o, sum_hi_o, cost_o;
  logic        flag_s, flag_o, busy, done;

  int checks = 0;
  int fails = 0;
  int mode = 0;
  logic [31:0] key = 32'h1357_9BDF;
  logic [31:0] cval_a = '0, cval_b = '0;
  logic [31:0] exp_pa = '0, exp_pb = '0, exp_step = '0;
  int reads = 0, addr_bad = 0;

  mac_seq_top u0 (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] mem_val(input bit side, input logic [31:0] addr);
    if (mode == 1) return side ? cval_b : cval_a;
    return (addr * 32'h9E37_79B1) ^ (side ? ~key : key) ^ (addr << 13);
  endfunction

  always @(posedge clk) if (mem_rd) begin
    mem_rdata_a <= mem_val(1'b0, mem_addr_a);
    mem_rdata_b <= mem_val(1'b1, mem_addr_b);
  end

  // R2 address monitor
  always @(negedge clk) if (!rst && mem_rd) begin
    if (mem_addr_a != exp_pa || mem_addr_b != exp_pb) addr_bad++;
    exp_pa = exp_pa + exp_step;
    exp_pb = exp_pb + exp_step;
    reads++;
  end

  function automatic logic [31:0] sbytes(input logic [1:0] s);
    return (s == 2'b00) ? 32'd1 : (s == 2'b01) ? 32'd2 : 32'd4;
  endfunction

  function automatic logic signed [31:0] sext_el(input logic [31:0] v, input logic [1:0] s);
    if (s == 2'b00) return {{24{v[7]}}, v[7:0]};
    if (s == 2'b01) return {{16{v[15]}}, v[15:0]};
    return v;
  endfunction

  function automatic logic [31:0] cost_of(input logic [31:0] n, input logic [1:0] s);
    if (s == 2'b00) return 32'd6 + 32'd7 * (n / 4) + 32'd4 * (n % 4);
    if (s == 2'b01) return 32'd6 + 32'd5 * (n / 2) + 32'd4 * (n % 2);
    return 32'd6 + 32'd4 * n;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [31:0] pa, input logic [31:0] pb, input logic [31:0] n,
                          input logic [1:0] sz, input logic [95:0] init, input bit poke);
    logic [95:0] acc = init;
    logic [31:0] hi;
    logic [31:0] sb = sbytes(sz);
    for (int i = 0; i < int'(n); i++) begin
      logic signed [31:0] ea, eb;
      logic signed [63:0] p;
      ea = sext_el(mem_val(1'b0, pa + sb * i), sz);
      eb = sext_el(mem_val(1'b1, pb + sb * i), sz);
      p = ea * eb;
      acc = acc + {{32{p[63]}}, p};
    end
    hi = acc[95:64];
    if (n != 0) hi = {{16{hi[15]}}, hi[15:0]};
    exp_pa = pa; exp_pb = pb; exp_step = sb; reads = 0; addr_bad = 0;
    @(negedge clk);
    ptr_a_in = pa; ptr_b_in = pb; count_in = n; esize_in = sz;
    {sum_hi_in, sum_mid_in, sum_lo_in} = init;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      ptr_a_in = pa + 32'h100; count_in = n + 5; esize_in = ~sz; sum_lo_in = ~init[31:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    // R4 R3 sum
    chk(sum_lo_o == acc[31:0], "R4 sum_lo", sum_lo_o, acc[31:0]);
    chk(sum_mid_o == acc[63:32], "R4 sum_mid", sum_mid_o, acc[63:32]);
    chk(sum_hi_o == hi, "R4 sum_hi", sum_hi_o, hi);
    // R5
    chk(ptr_a_o == pa + sb * n, "R5 ptr_a", ptr_a_o, pa + sb * n);
    chk(ptr_b_o == pb + sb * n, "R5 ptr_b", ptr_b_o, pb + sb * n);
    chk(count_o == 0, "R5 count", count_o, 0);
    // R6
    chk(flag_s == hi[31], "R6 flag_s", flag_s, hi[31]);
    chk(flag_o == (hi != 0 && hi != 32'hFFFF_FFFF), "R6 flag_o", flag_o,
        (hi != 0 && hi != 32'hFFFF_FFFF));
    // R7
    chk(cost_o == cost_of(n, sz), "R7 cost", cost_o, cost_of(n, sz));
    // R2 R10 reads and addresses
    chk(reads == int'(n) && addr_bad == 0, "R2 reads", reads, n);
    chk(busy == 1'b0, "R9 busy at done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R9 done pulse", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0_FFEE));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !mem_rd && !flag_s && !flag_o, "R1 controls", {busy, done, mem_rd}, 0);
    chk({sum_hi_o, sum_mid_o, sum_lo_o} == 0 && count_o == 0, "R1 results", sum_lo_o, 0);

    // R8 zero count: no reads, unchanged, no sign extension
    run_case(32'h40, 32'h80, 0, 2'b00, {32'h0001_2345, 32'h89AB_CDEF, 32'h1111_2222}, 1'b0);
    // R3 byte -128 * -128 with garbage upper bits, four elements
    mode = 1; cval_a = 32'hFFFF_FF80; cval_b = 32'h1234_5680;
    run_case(32'h1000, 32'h2000, 4, 2'b00, 96'd0, 1'b0);
    // R4 word extremes crossing into middle word
    cval_a = 32'h8000_0000; cval_b = 32'h8000_0000;
    run_case(32'h10, 32'h20, 3, 2'b10, 96'd0, 1'b0);
    // R4 R6 carry into hi bit 15 then sign extension, halfword
    cval_a = 32'hABCD_0001; cval_b = 32'h0000_0001;
    run_case(32'h0, 32'h100, 1, 2'b01, {32'h0000_7FFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, 1'b0);
    // R6 all ones high word gives no overflow
    cval_a = 32'h0; cval_b = 32'h5;
    run_case(32'h0, 32'h4, 1, 2'b10, {96{1'b1}}, 1'b0);
    // R9 start while busy ignored
    mode = 0;
    run_case(32'h300, 32'h700, 6, 2'b01, {32'h0, 32'h7, 32'h9}, 1'b1);
    // random mix including size code 11 (R3 word)
    for (int t = 0; t < 24; t++) begin
      key = $urandom;
      run_case($urandom & 32'h0FFF_FFFC, $urandom & 32'h0FFF_FFFC, $urandom % 13,
               2'($urandom % 4), {$urandom, $urandom, $urandom}, 1'b0);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule